// File: doc/BRIEF.md
# Rational Audio Clock Synthesizer

This block derives an audio sample-rate clock from a video pixel clock. A phase accumulator advances by a numerator on every pixel clock and wraps at a denominator. Each wrap toggles the audio clock. The numerator and denominator are picked per video standard and audio rate, so the audio clock is an exact rational fraction of the video timing. Over the frame period that makes the ratio whole, the number of audio samples per frame is exact.

A single output pin carries either the synthesized audio clock or a one-bit line phase error. The phase error is captured on every rising edge of the horizontal sync input. The choice is made by a bit of a control register. That register is written through a small synchronous port and can be read back. Two further bits of the same register are used by other logic. One turns off automatic tape-source detection. The other, together with the pin-source bit, moves the line pixel counter's wrap point. That wrap point is brought out as a value.

Top module: `acs_audio_clk_synth`

## Requirements
- R1: While reset is asserted, the shared pin is low, a read of control address 7 returns 0, vcr_auto_off is 0 and line_wrap_point is 512.
- R2: Standard codes select pixels per frame P and frame rate: 0 = 525-line 13.5 MHz (P=450450, 29.97 Hz), 1 = 625-line 13.5 MHz (P=540000, 25 Hz), 2 = 525-line square pixel (P=409500, 29.97 Hz), 3 = 625-line square pixel (P=590000, 25 Hz), 4 = 525-line four-times-subcarrier (P=477750, 29.97 Hz), 5 = 625-line four-times-subcarrier (P=709379, 25 Hz); codes 6 and 7 behave as code 0.
- R3: Rate codes 0, 1 and 2 select 48, 44.1 and 32 kHz, and code 3 behaves as code 0. At 25 Hz the increment N is 3840, 3528 or 2560 and the modulus M is P. At 29.97 Hz N is 16016, 294294 or 32032 and M is 5P, 100P or 15P. After k accumulator steps following a restart, the audio clock equals bit 0 of floor(k*N/M).
- R4: At the first clock edge where {std_sel, rate_sel} differs from its value at the previous edge, the accumulator clears and the audio clock goes low. The next edge is step 1. After reset the selection in effect is standard 0, rate 0.
- R5: A write with reg_we high and reg_addr equal to 7 stores reg_wdata in the control register. reg_rdata shows that register while reg_addr is 7 and 0 at any other address. Writes to other addresses change nothing.
- R6: Control bit 3 at 0 puts the audio clock on the shared pin. At 1 it puts the captured phase error there. The accumulator keeps running in both cases.
- R7: At an edge where hsync is 1 and was 0 at the previous edge, phase_err_in is captured. The captured bit holds at all other edges.
- R8: vcr_auto_off follows control bit 0.
- R9: line_wrap_point is 256 when control bit 3 and control bit 2 (VGA mode) are both 1, and 512 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 3 | Video standard code |
| rate_sel | input | 2 | Audio rate code |
| hsync | input | 1 | Horizontal sync, rising edge samples phase error |
| phase_err_in | input | 1 | One-bit line phase error |
| reg_we | input | 1 | Control port write strobe |
| reg_addr | input | 3 | Control port address |
| reg_wdata | input | 8 | Control port write data |
| reg_rdata | output | 8 | Control port read data |
| aclk_or_err_out | output | 1 | Shared pin: audio clock or phase error |
| vcr_auto_off | output | 1 | Automatic tape-source detection disabled |
| line_wrap_point | output | 10 | Line pixel counter wrap value |

## Verification
A control-register write that flips the pin source can land on the same edge as a rising hsync that captures a new phase-error bit. The bench drives both in one cycle, with the write turning the source on and a phase-error value opposite to the previously held bit. It expects the pin, in the cycle right after that edge, to show the newly captured bit and not the old bit or the audio clock. A selection change is also made on the same edge as writes, and the restart is judged against the floor(k*N/M) model with k reset to zero.

// File: rtl/acs_pkg.sv
package acs_pkg;

   // Widest modulus is 100 * 477750 = 47,775,000, which fits 26 bits.
   localparam int RATIO_W = 26;

   typedef struct packed {
      logic [RATIO_W-1:0] num;
      logic [RATIO_W-1:0] den;
   } ratio_t;

   // Pixels per frame for each standard code; codes above 5 alias code 0.
   function automatic int unsigned frame_pixels(input logic [2:0] std_code);
      case (std_code)
         3'd1:    return 32'd540000;
         3'd2:    return 32'd409500;
         3'd3:    return 32'd590000;
         3'd4:    return 32'd477750;
         3'd5:    return 32'd709379;
         default: return 32'd450450;
      endcase
   endfunction

   // 1 when the standard runs at the 30000/1001 frame rate.
   function automatic logic frame_is_ntsc(input logic [2:0] std_code);
      case (std_code)
         3'd1, 3'd3, 3'd5: return 1'b0;
         default:          return 1'b1;
      endcase
   endfunction

   // Toggle increment and modulus per pixel clock (two toggles per sample).
   function automatic ratio_t pick_ratio(input logic [2:0] std_code,
                                         input logic [1:0] rate_code);
      int unsigned ppf;
      int unsigned n;
      int unsigned m;
      ratio_t      r;
      ppf = frame_pixels(std_code);
      if (frame_is_ntsc(std_code)) begin
         case (rate_code)
            2'd1:    begin n = 32'd294294; m = 32'd100 * ppf; end
            2'd2:    begin n = 32'd32032;  m = 32'd15 * ppf;  end
            default: begin n = 32'd16016;  m = 32'd5 * ppf;   end
         endcase
      end else begin
         case (rate_code)
            2'd1:    n = 32'd3528;
            2'd2:    n = 32'd2560;
            default: n = 32'd3840;
         endcase
         m = ppf;
      end
      r.num = n[RATIO_W-1:0];
      r.den = m[RATIO_W-1:0];
      return r;
   endfunction

endpackage

// File: rtl/acs_ctrl_regs.sv
module acs_ctrl_regs #(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 7,
   parameter int SRC_BIT   = 3,
   parameter int VCR_BIT   = 0,
   parameter int VGA_BIT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              src_sel,
   output logic              vcr_off,
   output logic              vga_on
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic [DATA_W-1:0] ctrl_q;
   logic              hit;

   assign hit = (addr == CTRL_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we && hit) begin
         ctrl_q <= wdata;
      end
   end

   assign rdata   = hit ? ctrl_q : '0;
   assign src_sel = ctrl_q[SRC_BIT];
   assign vcr_off = ctrl_q[VCR_BIT];
   assign vga_on  = ctrl_q[VGA_BIT];

endmodule

// File: rtl/acs_rate_table.sv
module acs_rate_table #(
   parameter int ACC_W  = acs_pkg::RATIO_W,
   parameter int STD_W  = 3,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STD_W-1:0]  std_sel,
   input  logic [RATE_W-1:0] rate_sel,
   output logic [ACC_W-1:0]  num,
   output logic [ACC_W-1:0]  den,
   output logic              restart
);

   localparam int SEL_W = STD_W + RATE_W;

   acs_pkg::ratio_t   ratio;
   logic [SEL_W-1:0]  sel_now;
   logic [SEL_W-1:0]  sel_q;

   assign sel_now = {std_sel, rate_sel};

   always_comb begin
      ratio = acs_pkg::pick_ratio(std_sel, rate_sel);
      num   = ACC_W'(ratio.num);
      den   = ACC_W'(ratio.den);
   end

   // Selection seen at the previous edge; standard 0, rate 0 after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else begin
         sel_q <= sel_now;
      end
   end

   assign restart = (sel_now != sel_q);

endmodule

// File: rtl/acs_phase_accum.sv
module acs_phase_accum #(
   parameter int ACC_W = acs_pkg::RATIO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [ACC_W-1:0] num,
   input  logic [ACC_W-1:0] den,
   output logic [ACC_W-1:0] acc_q,
   output logic             tick_q
);

   localparam int SUM_W = ACC_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] den_x;
   logic             wrap;

   assign sum   = {1'b0, acc_q} + {1'b0, num};
   assign den_x = {1'b0, den};
   assign wrap  = (sum >= den_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (restart) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (wrap) begin
         acc_q  <= ACC_W'(sum - den_x);
         tick_q <= ~tick_q;
      end else begin
         acc_q  <= ACC_W'(sum);
      end
   end

endmodule

// File: rtl/acs_line_err_capture.sv
module acs_line_err_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync,
   input  logic err_in,
   output logic rise,
   output logic err_q
);

   logic hs_q;

   assign rise = hsync & ~hs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         hs_q <= hsync;
         if (rise) begin
            err_q <= err_in;
         end
      end
   end

endmodule

// File: rtl/acs_audio_clk_synth.sv
module acs_audio_clk_synth #(
   parameter int ACC_W     = acs_pkg::RATIO_W,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 7,
   parameter int SRC_BIT   = 3,
   parameter int VCR_BIT   = 0,
   parameter int VGA_BIT   = 2,
   parameter int WRAP_W    = 10,
   parameter int WRAP_FULL = 512,
   parameter int WRAP_HALF = 256,
   parameter bit PIN_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        std_sel,
   input  logic [1:0]        rate_sel,
   input  logic              hsync,
   input  logic              phase_err_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              aclk_or_err_out,
   output logic              vcr_auto_off,
   output logic [WRAP_W-1:0] line_wrap_point
);

   // Elaboration-time parameter checks
   if (ACC_W < acs_pkg::RATIO_W) begin : g_bad_acc
      $error("ACC_W too narrow for the largest modulus");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CTRL_ADDR outside the address range");
   end
   if (SRC_BIT >= DATA_W || VCR_BIT >= DATA_W || VGA_BIT >= DATA_W) begin : g_bad_bits
      $error("control bit position outside the data width");
   end
   if (WRAP_FULL >= (1 << WRAP_W) || WRAP_HALF >= (1 << WRAP_W)) begin : g_bad_wrap
      $error("wrap point does not fit WRAP_W");
   end

   logic [ACC_W-1:0] num;
   logic [ACC_W-1:0] den;
   logic [ACC_W-1:0] acc_q;
   logic             restart;
   logic             aclk_q;
   logic             hs_rise;
   logic             err_q;
   logic             src_sel;
   logic             vga_on;
   logic             pin_next;

   acs_ctrl_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTRL_ADDR(CTRL_ADDR),
      .SRC_BIT  (SRC_BIT),
      .VCR_BIT  (VCR_BIT),
      .VGA_BIT  (VGA_BIT)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .src_sel(src_sel),
      .vcr_off(vcr_auto_off),
      .vga_on (vga_on)
   );

   acs_rate_table #(
      .ACC_W (ACC_W),
      .STD_W (3),
      .RATE_W(2)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .std_sel (std_sel),
      .rate_sel(rate_sel),
      .num     (num),
      .den     (den),
      .restart (restart)
   );

   acs_phase_accum #(
      .ACC_W(ACC_W)
   ) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .num    (num),
      .den    (den),
      .acc_q  (acc_q),
      .tick_q (aclk_q)
   );

   acs_line_err_capture u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .hsync (hsync),
      .err_in(phase_err_in),
      .rise  (hs_rise),
      .err_q (err_q)
   );

   assign pin_next = src_sel ? err_q : aclk_q;

   // Shared pin: straight from registers, or retimed by one more flop.
   if (PIN_REG) begin : g_pin_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q <= 1'b0;
         end else begin
            pin_q <= pin_next;
         end
      end
      assign aclk_or_err_out = pin_q;
   end else begin : g_pin_direct
      assign aclk_or_err_out = pin_next;
   end

   assign line_wrap_point = (src_sel && vga_on) ? WRAP_W'(WRAP_HALF)
                                                : WRAP_W'(WRAP_FULL);

endmodule

// File: rtl/acs_audio_clk_chk.sv
module acs_audio_clk_chk #(
   parameter int ACC_W     = acs_pkg::RATIO_W,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 7,
   parameter int VCR_BIT   = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        std_sel,
   input logic [1:0]        rate_sel,
   input logic [ACC_W-1:0]  acc_q,
   input logic [ACC_W-1:0]  num,
   input logic [ACC_W-1:0]  den,
   input logic              aclk_q,
   input logic              hs_rise,
   input logic              err_q,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              vcr_auto_off
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic [4:0] sel;
   assign sel = {std_sel, rate_sel};

   // R4: a selection change clears accumulator and audio clock
   a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel != $past(sel)) |=> (acc_q == '0 && !aclk_q));

   // R3: with a steady selection the phase stays below the modulus
   a_r3_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel == $past(sel)) |-> (acc_q < den));

   // R3: the audio clock only moves right after a wrap or a restart
   a_r3_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel == $past(sel) && aclk_q != $past(aclk_q)) |-> (acc_q < num));

   // R7: captured phase error changes only after a rising hsync
   a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && err_q != $past(err_q)) |-> $past(hs_rise));

   // R5: other addresses read as zero
   a_r5_rdata_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != CTRL_A) |-> (reg_rdata == '0));

   // R8: detection-off flag rises only from a write setting that bit
   a_r8_vcr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && vcr_auto_off && !$past(vcr_auto_off))
         |-> $past(reg_we && reg_addr == CTRL_A && reg_wdata[VCR_BIT]));

endmodule

bind acs_audio_clk_synth acs_audio_clk_chk #(
   .ACC_W    (ACC_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTRL_ADDR(CTRL_ADDR),
   .VCR_BIT  (VCR_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .std_sel     (std_sel),
   .rate_sel    (rate_sel),
   .acc_q       (acc_q),
   .num         (num),
   .den         (den),
   .aclk_q      (aclk_q),
   .hs_rise     (hs_rise),
   .err_q       (err_q),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .vcr_auto_off(vcr_auto_off)
);

// File: tb/test_acs_audio_clk_synth.sv
module test_acs_audio_clk_synth;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] std_sel = '0;
   logic [1:0] rate_sel = '0;
   logic       hsync = 1'b0;
   logic       phase_err_in = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd7;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       pin;
   logic       vcr_off;
   logic [9:0] wrap_pt;

   always #4 clk = ~clk;   // 125 MHz

   acs_audio_clk_synth i_acs_audio_clk_synth (
      .clk            (clk),
      .rst_n          (rst_n),
      .std_sel        (std_sel),
      .rate_sel       (rate_sel),
      .hsync          (hsync),
      .phase_err_in   (phase_err_in),
      .reg_we         (reg_we),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .aclk_or_err_out(pin),
      .vcr_auto_off   (vcr_off),
      .line_wrap_point(wrap_pt)
   );

   typedef struct {
      logic       pin;
      logic [7:0] rdata;
      logic       vcr;
      logic [9:0] wrap;
      string      tag;
   } exp_t;

   exp_t sbq[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   // Model state, built from the requirements
   logic [2:0] d_std = '0;
   logic [1:0] d_rate = '0;
   logic [2:0] prev_std = '0;   // R4: selection after reset is 0/0
   logic [1:0] prev_rate = '0;
   logic       prev_hs = 1'b0;
   logic [7:0] reg_m = '0;
   logic       perr_m = 1'b0;
   longint     k = 0;

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // R2/R3 ratio table
   function automatic void bench_ratio(input int s, input int r,
                                       output longint n, output longint m);
      longint p;
      bit     ntsc;
      case (s)
         1: begin p = 540000; ntsc = 0; end
         2: begin p = 409500; ntsc = 1; end
         3: begin p = 590000; ntsc = 0; end
         4: begin p = 477750; ntsc = 1; end
         5: begin p = 709379; ntsc = 0; end
         default: begin p = 450450; ntsc = 1; end
      endcase
      if (ntsc) begin
         if (r == 1)      begin n = 294294; m = 100 * p; end
         else if (r == 2) begin n = 32032;  m = 15 * p;  end
         else             begin n = 16016;  m = 5 * p;   end
      end else begin
         if (r == 1)      n = 3528;
         else if (r == 2) n = 2560;
         else             n = 3840;
         m = p;
      end
   endfunction

   // Driver: sets inputs for one edge and pushes the expected result
   task automatic tick(input logic hs, input logic pe, input logic we,
                       input logic [2:0] a, input logic [7:0] wd);
      exp_t   e;
      longint n;
      longint m;
      @(negedge clk);
      std_sel      = d_std;
      rate_sel     = d_rate;
      hsync        = hs;
      phase_err_in = pe;
      reg_we       = we;
      reg_addr     = a;
      reg_wdata    = wd;
      if ({d_std, d_rate} != {prev_std, prev_rate}) k = 0;   // R4
      else k++;
      prev_std  = d_std;
      prev_rate = d_rate;
      if (we && a == 3'd7) reg_m = wd;                        // R5
      if (hs && !prev_hs) perr_m = pe;                        // R7
      prev_hs = hs;
      bench_ratio(int'(d_std), int'(d_rate), n, m);
      e.pin   = reg_m[3] ? perr_m : logic'(((k * n) / m) & 1);
      e.tag   = reg_m[3] ? "R6" : ((k == 0) ? "R4" : "R3");
      e.rdata = (a == 3'd7) ? reg_m : 8'h00;
      e.vcr   = reg_m[0];
      e.wrap  = (reg_m[3] && reg_m[2]) ? 10'd256 : 10'd512;
      sbq.push_back(e);
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) tick(1'b0, 1'b0, 1'b0, 3'd7, 8'h00);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      tick(1'b0, 1'b0, 1'b1, a, d);
   endtask

   // Monitor: compares 2 ns after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check({e.tag, " pin"}, longint'(pin), longint'(e.pin));
            check("R5 rdata", longint'(reg_rdata), longint'(e.rdata));
            check("R8 vcr_auto_off", longint'(vcr_off), longint'(e.vcr));
            check("R9 wrap point", longint'(wrap_pt), longint'(e.wrap));
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #21;
      check("R1 pin in reset", longint'(pin), 0);
      check("R1 rdata in reset", longint'(reg_rdata), 0);
      check("R1 vcr in reset", longint'(vcr_off), 0);
      check("R1 wrap in reset", longint'(wrap_pt), 512);
      @(negedge clk);
      rst_n = 1'b1;

      // R2, R3, R4: every standard and rate code, including aliases
      for (int s = 0; s < 8; s++) begin
         for (int r = 0; r < 4; r++) begin
            d_std  = 3'(7 - s);
            d_rate = 2'(r ^ (s & 1));
            idle(1400);
         end
      end

      // R5: write elsewhere is ignored, control register reads back
      wr(3'd5, 8'hFF);
      idle(3);
      wr(3'd7, 8'h02);
      tick(1'b0, 1'b0, 1'b0, 3'd4, 8'h00);
      idle(2);

      // R6/R7 same-edge case: source swap together with a rising hsync
      d_std  = 3'd1;
      d_rate = 2'd0;
      idle(50);
      tick(1'b1, 1'b1, 1'b1, 3'd7, 8'h08);
      idle(4);
      // R7: phase error changing while hsync stays high is not captured
      tick(1'b1, 1'b0, 1'b0, 3'd7, 8'h00);
      tick(1'b1, 1'b0, 1'b0, 3'd7, 8'h00);
      for (int i = 0; i < 40; i++) begin
         tick(1'b1, logic'((i ^ (i >> 2)) & 1), 1'b0, 3'd7, 8'h00);
         tick(1'b0, logic'(i & 1), 1'b0, 3'd7, 8'h00);
         idle(3);
      end

      // R9: VGA bit with and without the source bit
      wr(3'd7, 8'h0C);
      idle(5);
      wr(3'd7, 8'h04);
      idle(5);
      // R8: detection-off bit, combined with a selection change (R4)
      d_std = 3'd4;
      wr(3'd7, 8'h01);
      idle(5);
      // R6: back to the audio clock, accumulator kept running
      wr(3'd7, 8'h00);
      idle(3000);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule